// File: doc/BRIEF.md
# External Bus Chip-Select Sequencer

This block owns the address outputs and the active-low chip-select lines of a separate (non-multiplexed) external memory bus. On every bus-cycle clock the processor side offers one request: an external access carrying an address, an access to on-chip ROM/RAM, or no access at all. The block compares the external address against four programmable windows. It then decides, for that cycle boundary, whether the address outputs take a new value and which select line, if any, is driven low.

A select line is not a simple echo of each access. It is released only when the following cycle goes somewhere else. Back-to-back accesses to one window keep the same line low without a gap. Cycles with no bus activity freeze both the address and the select. An on-chip access drops the select but leaves the last external address on the pins. Because these rules chain, one select can stay low across many cycles. An external address that falls in no window drives no select and raises an error flag for that cycle.

Top module: `ext_cs_seq`

## Requirements
- R1: While reset is applied, and until the first request after it is released, every bit of `bus_cs_n` is 1, `bus_addr` is 0 and `bus_err` is 0.
- R2: An external request (`req_type` = 2) that falls in window k drives `bus_addr` to `req_addr` and drives only `bus_cs_n[k]` low. Both take effect at the same clock edge that ends the request cycle.
- R3: An external request to window j that follows an external access to a different window i raises `bus_cs_n[i]` and lowers `bus_cs_n[j]` at the same edge that loads the new address.
- R4: Consecutive external requests to the same window keep that select low through every cycle, while `bus_addr` follows each new address.
- R5: An on-chip request (`req_type` = 1) drives every select high, leaves `bus_addr` unchanged and clears `bus_err`.
- R6: A no-access request (`req_type` = 0) leaves `bus_addr` and `bus_cs_n` unchanged and clears `bus_err`. Runs of such cycles and same-window accesses therefore chain, keeping one select low for any number of cycles.
- R7: Window i is described by base `cfg_base[i*24 +: 24]` and size `cfg_size[i*24 +: 24]`. An address matches when base <= address < base + size. A size of 0 disables the window, and configured windows do not wrap past the top of the address space.
- R8: When an address lies in several windows, the window with the lowest index is selected.
- R9: An external request whose address matches no window still loads `bus_addr`, drives every select high and sets `bus_err` to 1 for that cycle only. `bus_err` is 0 after any other request.
- R10: At most one bit of `bus_cs_n` is low in any cycle.
- R11: The value 3 on `req_type` is treated exactly like a no-access request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus-cycle clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronised internally over two edges |
| req_type | input | 2 | Cycle kind: 0 none, 1 on-chip, 2 external, 3 treated as none |
| req_addr | input | 24 | Address of the request, used when `req_type` is 2 |
| cfg_base | input | 96 | Four window base addresses, window i in bits [i*24 +: 24] |
| cfg_size | input | 96 | Four window sizes, window i in bits [i*24 +: 24]; 0 disables |
| bus_addr | output | 24 | Registered external address bus |
| bus_cs_n | output | 4 | Registered active-low chip selects, one per window |
| bus_err | output | 1 | Registered flag: last external request hit no window |

## Verification
All of the block's state is visible directly on its outputs, so any wrong internal value appears on `bus_addr`, `bus_cs_n` or `bus_err` at the first sampling point after the clock edge that loaded it. A reference model in the bench tracks the expected address, the selected window and the error flag for every request, and the outputs are compared with it on every cycle. A hold fault shows up as an address or select that moves on an idle or on-chip cycle. A release fault shows up as a select that stays low after an on-chip cycle, or that drops out between same-window accesses. A decode or priority fault selects the wrong line in the same cycle as the bad access.

// File: rtl/csq_pkg.sv
package csq_pkg;
  typedef enum logic [1:0] {
    CYC_NONE = 2'd0,
    CYC_INT  = 2'd1,
    CYC_EXT  = 2'd2,
    CYC_RSVD = 2'd3
  } cyc_e;
endpackage

// File: rtl/csq_rst_sync.sv
module csq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic [1:0] stage_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stage_q <= 2'b00;
    else        stage_q <= {stage_q[0], 1'b1};
  end

  assign rst_n_sync = stage_q[1];
endmodule

// File: rtl/csq_area_match.sv
module csq_area_match #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4
) (
  input  logic [ADDR_W-1:0]        addr,
  input  logic [N_AREA*ADDR_W-1:0] cfg_base,
  input  logic [N_AREA*ADDR_W-1:0] cfg_size,
  output logic                     hit_any,
  output logic [N_AREA-1:0]        sel
);
  logic [N_AREA-1:0] hit;

  // Per-window range compare: offset from base must be below the size.
  for (genvar g = 0; g < N_AREA; g++) begin : g_win
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] size;
    assign base   = cfg_base[g*ADDR_W +: ADDR_W];
    assign size   = cfg_size[g*ADDR_W +: ADDR_W];
    assign offs   = addr - base;
    assign hit[g] = (size != '0) && (offs < size);
  end

  // Lowest index wins when windows overlap.
  always_comb begin
    sel = '0;
    for (int i = N_AREA - 1; i >= 0; i--) begin
      if (hit[i]) sel = N_AREA'(1) << i;
    end
  end

  assign hit_any = |hit;
endmodule

// File: rtl/csq_next.sv
module csq_next
  import csq_pkg::*;
#(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4
) (
  input  logic [1:0]        req_type,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              hit_any,
  input  logic [N_AREA-1:0] sel,
  output logic [ADDR_W-1:0] addr_d,
  output logic              addr_en,
  output logic [N_AREA-1:0] cs_n_d,
  output logic              cs_en,
  output logic              err_d
);
  cyc_e kind;
  assign kind = cyc_e'(req_type);

  always_comb begin
    addr_d  = req_addr;
    addr_en = 1'b0;
    cs_n_d  = '1;
    cs_en   = 1'b0;
    err_d   = 1'b0;
    unique case (kind)
      CYC_EXT: begin
        addr_en = 1'b1;
        cs_en   = 1'b1;
        cs_n_d  = ~sel;
        err_d   = ~hit_any;
      end
      CYC_INT: begin
        cs_en  = 1'b1;
        cs_n_d = '1;
      end
      CYC_NONE, CYC_RSVD: begin
        addr_en = 1'b0;
        cs_en   = 1'b0;
      end
      default: begin
        addr_en = 1'b0;
      end
    endcase
  end
endmodule

// File: rtl/ext_cs_seq.sv
module ext_cs_seq #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4
) (
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [1:0]               req_type,
  input  logic [ADDR_W-1:0]        req_addr,
  input  logic [N_AREA*ADDR_W-1:0] cfg_base,
  input  logic [N_AREA*ADDR_W-1:0] cfg_size,
  output logic [ADDR_W-1:0]        bus_addr,
  output logic [N_AREA-1:0]        bus_cs_n,
  output logic                     bus_err
);
  logic                rst_n_sync;
  logic                hit_any;
  logic [N_AREA-1:0]   sel;
  logic [ADDR_W-1:0]   addr_d, addr_q;
  logic [N_AREA-1:0]   cs_n_d, cs_n_q;
  logic                addr_en, cs_en, err_d, err_q;

  csq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_sync)
  );

  csq_area_match #(.ADDR_W(ADDR_W), .N_AREA(N_AREA)) u_match (
    .addr     (req_addr),
    .cfg_base (cfg_base),
    .cfg_size (cfg_size),
    .hit_any  (hit_any),
    .sel      (sel)
  );

  csq_next #(.ADDR_W(ADDR_W), .N_AREA(N_AREA)) u_next (
    .req_type (req_type),
    .req_addr (req_addr),
    .hit_any  (hit_any),
    .sel      (sel),
    .addr_d   (addr_d),
    .addr_en  (addr_en),
    .cs_n_d   (cs_n_d),
    .cs_en    (cs_en),
    .err_d    (err_d)
  );

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync)  addr_q <= '0;
    else if (addr_en) addr_q <= addr_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) cs_n_q <= '1;
    else if (cs_en)  cs_n_q <= cs_n_d;
  end

  always_ff @(posedge clk or negedge rst_n_sync) begin
    if (!rst_n_sync) err_q <= 1'b0;
    else             err_q <= err_d;
  end

  assign bus_addr = addr_q;
  assign bus_cs_n = cs_n_q;
  assign bus_err  = err_q;
endmodule

// File: rtl/ext_cs_seq_chk.sv
module ext_cs_seq_chk #(
  parameter int ADDR_W = 24,
  parameter int N_AREA = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic [1:0]        req_type,
  input logic [ADDR_W-1:0] req_addr,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [N_AREA-1:0] bus_cs_n,
  input logic              bus_err
);
  // R10
  one_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(~bus_cs_n));

  // R6 R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_type == 2'd0 || req_type == 2'd3) |=>
      ($stable(bus_addr) && $stable(bus_cs_n) && !bus_err));

  // R5
  int_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_type == 2'd1) |=> ((&bus_cs_n) && $stable(bus_addr) && !bus_err));

  // R2
  ext_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_type == 2'd2) |=> (bus_addr == $past(req_addr)));

  // R9
  err_nocs_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_type == 2'd2) |=> (bus_err == (&bus_cs_n)));
endmodule

bind ext_cs_seq ext_cs_seq_chk #(.ADDR_W(ADDR_W), .N_AREA(N_AREA)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n_sync),
  .req_type (req_type),
  .req_addr (req_addr),
  .bus_addr (bus_addr),
  .bus_cs_n (bus_cs_n),
  .bus_err  (bus_err)
);

// File: tb/sim_ext_cs_seq.sv
module sim_ext_cs_seq;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 24;
  localparam int NA = 4;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [1:0]    req_type;
  logic [AW-1:0] req_addr;
  logic [NA*AW-1:0] cfg_base, cfg_size;
  logic [AW-1:0] bus_addr;
  logic [NA-1:0] bus_cs_n;
  logic          bus_err;

  ext_cs_seq #(.ADDR_W(AW), .N_AREA(NA)) u0 (
    .clk(clk), .rst_n(rst_n), .req_type(req_type), .req_addr(req_addr),
    .cfg_base(cfg_base), .cfg_size(cfg_size),
    .bus_addr(bus_addr), .bus_cs_n(bus_cs_n), .bus_err(bus_err)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  // Window table (window 3 sits inside window 1 to exercise priority)
  longint win_base [NA] = '{64'h100000, 64'h200000, 64'h400000, 64'h200800};
  longint win_size [NA] = '{64'h010000, 64'h100000, 64'h001000, 64'h000100};

  always_comb begin
    for (int i = 0; i < NA; i++) begin
      cfg_base[i*AW +: AW] = AW'(win_base[i]);
      cfg_size[i*AW +: AW] = AW'(win_size[i]);
    end
  end

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;
  string cur_tag = "R1";

  // Behavioural reference state
  longint m_addr;
  int     m_win;
  bit     m_err;

  function automatic int find_win(longint a);
    for (int i = 0; i < NA; i++)
      if (win_size[i] != 0 && a >= win_base[i] && a < win_base[i] + win_size[i])
        return i;
    return -1;
  endfunction

  function automatic logic [NA-1:0] exp_cs(int w);
    logic [NA-1:0] v = '1;
    if (w >= 0) v[w] = 1'b0;
    return v;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_addr <= 0; m_win <= -1; m_err <= 0;
    end else begin
      case (req_type)
        2'd2: begin
          m_addr <= longint'(req_addr);
          m_win  <= find_win(longint'(req_addr));
          m_err  <= (find_win(longint'(req_addr)) < 0);
        end
        2'd1: begin m_win <= -1; m_err <= 0; end
        default: m_err <= 0;
      endcase
    end
  end

  task automatic compare(string tag);
    n_tests++;
    if (bus_addr !== AW'(m_addr) || bus_cs_n !== exp_cs(m_win) || bus_err !== m_err) begin
      n_fail++;
      $display("FAIL %s addr=%h/%h cs_n=%b/%b err=%b/%b", tag,
               bus_addr, AW'(m_addr), bus_cs_n, exp_cs(m_win), bus_err, m_err);
    end
  endtask

  task automatic step(logic [1:0] t, longint a, string tag);
    @(negedge clk);
    compare(cur_tag);
    req_type = t;
    req_addr = AW'(a);
    cur_tag  = tag;
  endtask

  task automatic check_reset_state(string tag);
    n_tests++;
    if (bus_addr !== '0 || bus_cs_n !== '1 || bus_err !== 1'b0) begin
      n_fail++;
      $display("FAIL %s addr=%h/0 cs_n=%b/1111 err=%b/0", tag, bus_addr, bus_cs_n, bus_err);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 1'b0; req_type = 2'd0; req_addr = '0;
    repeat (3) @(negedge clk);
    check_reset_state("R1 in reset");
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check_reset_state("R1 after release");

    // Area i then area j (R3), internal after external (R5)
    step(2, 64'h100010, "R2 first ext win0");
    step(2, 64'h400020, "R3 win0->win2");
    step(2, 64'h100040, "R3 win2->win0");
    step(1, 64'h555555, "R5 internal after ext");
    step(0, 64'h000000, "R6 idle after internal");
    // Same area chain with idles (R4, R6)
    step(2, 64'h200004, "R2 ext win1");
    step(2, 64'h2FFF00, "R4 same win1");
    step(0, 64'h123456, "R6 idle holds win1");
    step(3, 64'h654321, "R11 type3 holds win1");
    step(0, 64'h000000, "R6 idle chain");
    step(2, 64'h200100, "R4 same win1 after idles");
    // Priority and decode edges (R7, R8)
    step(2, 64'h200800, "R8 overlap picks win1");
    step(2, 64'h1FFFFF, "R7 below win1 base");
    step(2, 64'h10FFFF, "R7 last byte win0");
    step(2, 64'h110000, "R7 one past win0");
    step(0, 64'h000000, "R9 err clears on idle");
    step(2, 64'h400FFF, "R7 last byte win2");
    step(2, 64'h401000, "R9 unmatched after win2");
    step(2, 64'h401000, "R9 unmatched repeat");
    step(1, 64'h000000, "R5 internal clears err");

    // Randomised mix, biased toward window contents
    for (int k = 0; k < 3000; k++) begin
      int  t = $urandom_range(0, 3);
      int  w = $urandom_range(0, NA);
      longint a;
      if (w < NA) a = win_base[w] + longint'($urandom_range(0, int'(win_size[w]) - 1));
      else        a = longint'($urandom_range(0, 32'hFFFFFF));
      step(2'(t), a, (t == 2) ? "R2 R10 random ext" : (t == 1) ? "R5 random int" : "R6 R11 random hold");
    end

    // Reset in the middle of activity
    step(2, 64'h100000, "R2 pre-reset ext");
    @(negedge clk);
    compare(cur_tag);
    rst_n = 1'b0;
    req_type = 2'd0;
    #1;
    check_reset_state("R1 async mid-run");
    @(negedge clk);
    rst_n = 1'b1;
    cur_tag = "R1 held after release";
    repeat (3) step(0, 64'h0, "R1 held after release");
    step(2, 64'h200000, "R2 ext after reset");
    step(0, 64'h0, "R6 final hold");
    @(negedge clk);
    compare(cur_tag);
    finish_run();
  end
endmodule